// File: doc/BRIEF.md
# Receive DMA Suspend-State Controller

This block is the control state machine of a receive DMA engine. The engine moves frames from a receive FIFO into host buffers. Each buffer is described by a descriptor whose top bit says whether the DMA or the host owns it. The controller fetches descriptors through a simple request/valid port and starts a frame transfer when it holds a DMA-owned descriptor and the FIFO has a frame. When it meets a host-owned descriptor, it parks in a suspended state.

While suspended, a new frame arriving in the FIFO makes the controller read the same descriptor again. If the host has since handed the descriptor over, reception resumes. If not, the frame at the head of the FIFO is thrown away through a drop handshake and counted as missed, and the check repeats for every frame still queued. A mode input can keep frames in the FIFO instead of dropping them. A host poll strobe also wakes the controller for one refetch. A sticky buffer-unavailable flag reports every host-owned descriptor the controller meets, and a saturating missed-frame counter clears when it is read.

Top module: `rxdma_susp_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller goes to Stopped. After that edge, `state_o`, every request output, `rbu_o`, `miss_cnt_o` and `desc_cur_o` read zero.
- R2: A `start_i` pulse in Stopped starts a descriptor fetch. `desc_req_o` stays high until the cycle in which `desc_vld_i` is seen, and drops on the next edge.
- R3: A fetched word with bit 31 set (DMA owned) leads to Run. In Run, when `frm_avail_i` is high, `rx_busy_o` goes high and stays high until `frm_done_i`. The controller then fetches the next descriptor.
- R4: A fetched word with bit 31 clear (host owned) sets `rbu_o`. If the fetch was started by `start_i`, `poll_i` or the end of a transfer, the controller then goes to Suspend and drops nothing.
- R5: In Suspend, `frm_arrive_i` or `poll_i` each cause exactly one refetch. Both in the same cycle also cause exactly one refetch. With neither, the controller stays in Suspend.
- R6: A refetch started by a frame arrival that returns a host-owned word, while `flush_dis_i` is low, raises `drop_req_o` until `drop_ack_i`. The ack cycle adds one to `miss_cnt_o`.
- R7: One cycle after a drop is acknowledged, the controller refetches again, again as a frame-started fetch, if `frm_avail_i` is still high. Otherwise it returns to Suspend.
- R8: With `flush_dis_i` high, a host-owned frame-started refetch drops nothing and leaves `miss_cnt_o` unchanged. The controller returns to Suspend and the frame stays queued.
- R9: `miss_cnt_o` holds at its all-ones value instead of wrapping.
- R10: A `miss_rd_i` pulse clears `miss_cnt_o` on the next edge. If a drop is acknowledged in the same cycle, the counter reads 1 instead.
- R11: `stop_i` returns the controller to Stopped from Run (no transfer active) and from Suspend. It is ignored during a fetch, a transfer, a drop or the recheck cycle.
- R12: `rbu_clr_i` clears `rbu_o` on the next edge, unless a host-owned word is accepted in the same cycle, in which case `rbu_o` stays set.
- R13: `state_o` reports 0 for Stopped, 1 while fetching, 2 in Run or during a transfer, and 3 in Suspend, during a drop and during the recheck cycle.
- R14: `desc_cur_o` takes the word accepted with `desc_vld_i` on the next edge and holds it until the next accepted fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Host start strobe |
| stop_i | input | 1 | Host stop strobe |
| poll_i | input | 1 | Host poll-demand strobe |
| flush_dis_i | input | 1 | Mode bit: keep frames instead of dropping them |
| frm_arrive_i | input | 1 | One-cycle pulse per frame written into the FIFO |
| frm_avail_i | input | 1 | FIFO holds at least one complete frame |
| frm_done_i | input | 1 | Current frame transfer finished |
| drop_ack_i | input | 1 | FIFO has discarded its head frame |
| desc_vld_i | input | 1 | Descriptor word valid |
| desc_word_i | input | DESC_W | First descriptor word, ownership in bit OWN_BIT |
| miss_rd_i | input | 1 | Read strobe for the missed-frame counter |
| rbu_clr_i | input | 1 | Clear strobe for the buffer-unavailable flag |
| desc_req_o | output | 1 | Descriptor fetch request |
| rx_busy_o | output | 1 | Frame transfer in progress |
| drop_req_o | output | 1 | Request to discard the head frame |
| rbu_o | output | 1 | Sticky buffer-unavailable status |
| miss_cnt_o | output | CNT_W | Missed-frame count |
| desc_cur_o | output | DESC_W | Last accepted descriptor word |
| state_o | output | 2 | Reported process state |

## Verification
A wrong internal state shows up at the ports within one clock. The outputs are registered copies of the next state, so a bad transition makes `state_o` or one of the request lines disagree with the reference on the very next edge. A fetch reason stored wrongly does not show up until a host-owned word returns. At that point `drop_req_o` either appears or stays low, and `miss_cnt_o` moves or does not one cycle after the ack. The bench therefore stresses suspended refetches with both reasons, several queued frames, and reads and clears that coincide with drops.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_FETCH = 3'd1,
    ST_RUN   = 3'd2,
    ST_XFER  = 3'd3,
    ST_SUSP  = 3'd4,
    ST_DROP  = 3'd5,
    ST_RECHK = 3'd6
  } rxs_state_e;

  typedef enum logic {
    WHY_PLAIN = 1'b0,
    WHY_FRAME = 1'b1
  } fetch_why_e;

  localparam logic [1:0] CODE_STOP  = 2'd0;
  localparam logic [1:0] CODE_FETCH = 2'd1;
  localparam logic [1:0] CODE_RUN   = 2'd2;
  localparam logic [1:0] CODE_SUSP  = 2'd3;

  function automatic logic [1:0] state_code(rxs_state_e s);
    case (s)
      ST_STOP:                    return CODE_STOP;
      ST_FETCH:                   return CODE_FETCH;
      ST_RUN, ST_XFER:            return CODE_RUN;
      ST_SUSP, ST_DROP, ST_RECHK: return CODE_SUSP;
      default:                    return CODE_STOP;
    endcase
  endfunction

endpackage

// File: rtl/rxs_fsm.sv
module rxs_fsm
  import rxs_pkg::*;
#(
  parameter int DESC_W  = 32,
  parameter int OWN_BIT = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              poll_i,
  input  logic              flush_dis_i,
  input  logic              frm_arrive_i,
  input  logic              frm_avail_i,
  input  logic              frm_done_i,
  input  logic              drop_ack_i,
  input  logic              desc_vld_i,
  input  logic [DESC_W-1:0] desc_word_i,
  output logic              desc_req_o,
  output logic              rx_busy_o,
  output logic              drop_req_o,
  output logic              rbu_set_o,
  output logic              miss_inc_o,
  output logic [DESC_W-1:0] desc_cur_o,
  output logic [1:0]        state_o
);

  rxs_state_e st_q, st_d;
  fetch_why_e why_q, why_d;
  logic       desc_own;

  assign desc_own = desc_word_i[OWN_BIT];

  always_comb begin
    st_d       = st_q;
    why_d      = why_q;
    rbu_set_o  = 1'b0;
    miss_inc_o = 1'b0;
    unique case (st_q)
      ST_STOP: begin
        if (start_i) begin
          st_d  = ST_FETCH;
          why_d = WHY_PLAIN;
        end
      end
      ST_FETCH: begin
        if (desc_vld_i) begin
          if (desc_own) begin
            st_d = ST_RUN;
          end else begin
            rbu_set_o = 1'b1;
            st_d = (why_q == WHY_FRAME && !flush_dis_i) ? ST_DROP : ST_SUSP;
          end
        end
      end
      ST_RUN: begin
        if (stop_i)           st_d = ST_STOP;
        else if (frm_avail_i) st_d = ST_XFER;
      end
      ST_XFER: begin
        if (frm_done_i) begin
          st_d  = ST_FETCH;
          why_d = WHY_PLAIN;
        end
      end
      ST_SUSP: begin
        if (stop_i) begin
          st_d = ST_STOP;
        end else if (frm_arrive_i) begin
          st_d  = ST_FETCH;
          why_d = WHY_FRAME;
        end else if (poll_i) begin
          st_d  = ST_FETCH;
          why_d = WHY_PLAIN;
        end
      end
      ST_DROP: begin
        if (drop_ack_i) begin
          miss_inc_o = 1'b1;
          st_d       = ST_RECHK;
        end
      end
      ST_RECHK: begin
        if (frm_avail_i) begin
          st_d  = ST_FETCH;
          why_d = WHY_FRAME;
        end else begin
          st_d = ST_SUSP;
        end
      end
      default: st_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_STOP;
      why_q      <= WHY_PLAIN;
      desc_req_o <= 1'b0;
      rx_busy_o  <= 1'b0;
      drop_req_o <= 1'b0;
      state_o    <= CODE_STOP;
    end else begin
      st_q       <= st_d;
      why_q      <= why_d;
      desc_req_o <= (st_d == ST_FETCH);
      rx_busy_o  <= (st_d == ST_XFER);
      drop_req_o <= (st_d == ST_DROP);
      state_o    <= state_code(st_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              desc_cur_o <= '0;
    else if (st_q == ST_FETCH && desc_vld_i) desc_cur_o <= desc_word_i;
  end

endmodule

// File: rtl/rxs_miss_cnt.sv
module rxs_miss_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (rd_i) begin
      cnt_o <= inc_i ? CNT_ONE : '0;
    end else if (inc_i && cnt_o != CNT_MAX) begin
      cnt_o <= cnt_o + CNT_ONE;
    end
  end

endmodule

// File: rtl/rxs_flag.sv
module rxs_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

endmodule

// File: rtl/rxdma_susp_ctrl.sv
module rxdma_susp_ctrl #(
  parameter int CNT_W   = 16,
  parameter int DESC_W  = 32,
  parameter int OWN_BIT = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              poll_i,
  input  logic              flush_dis_i,
  input  logic              frm_arrive_i,
  input  logic              frm_avail_i,
  input  logic              frm_done_i,
  input  logic              drop_ack_i,
  input  logic              desc_vld_i,
  input  logic [DESC_W-1:0] desc_word_i,
  input  logic              miss_rd_i,
  input  logic              rbu_clr_i,
  output logic              desc_req_o,
  output logic              rx_busy_o,
  output logic              drop_req_o,
  output logic              rbu_o,
  output logic [CNT_W-1:0]  miss_cnt_o,
  output logic [DESC_W-1:0] desc_cur_o,
  output logic [1:0]        state_o
);

  logic rbu_set;
  logic miss_inc;

  rxs_fsm #(.DESC_W(DESC_W), .OWN_BIT(OWN_BIT)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .poll_i       (poll_i),
    .flush_dis_i  (flush_dis_i),
    .frm_arrive_i (frm_arrive_i),
    .frm_avail_i  (frm_avail_i),
    .frm_done_i   (frm_done_i),
    .drop_ack_i   (drop_ack_i),
    .desc_vld_i   (desc_vld_i),
    .desc_word_i  (desc_word_i),
    .desc_req_o   (desc_req_o),
    .rx_busy_o    (rx_busy_o),
    .drop_req_o   (drop_req_o),
    .rbu_set_o    (rbu_set),
    .miss_inc_o   (miss_inc),
    .desc_cur_o   (desc_cur_o),
    .state_o      (state_o)
  );

  rxs_miss_cnt #(.CNT_W(CNT_W)) u_miss (
    .clk   (clk),
    .rst   (rst),
    .inc_i (miss_inc),
    .rd_i  (miss_rd_i),
    .cnt_o (miss_cnt_o)
  );

  rxs_flag u_rbu (
    .clk    (clk),
    .rst    (rst),
    .set_i  (rbu_set),
    .clr_i  (rbu_clr_i),
    .flag_o (rbu_o)
  );

endmodule

// File: rtl/rxs_chk.sv
module rxs_chk #(
  parameter int CNT_W   = 16,
  parameter int DESC_W  = 32,
  parameter int OWN_BIT = 31
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              stop_i,
  input logic              drop_ack_i,
  input logic              desc_vld_i,
  input logic [DESC_W-1:0] desc_word_i,
  input logic              miss_rd_i,
  input logic              desc_req_o,
  input logic              rx_busy_o,
  input logic              drop_req_o,
  input logic              rbu_o,
  input logic [CNT_W-1:0]  miss_cnt_o,
  input logic [DESC_W-1:0] desc_cur_o,
  input logic [1:0]        state_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2
  fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    desc_req_o && !desc_vld_i |=> desc_req_o);

  // R2
  fetch_release_chk: assert property (@(posedge clk) disable iff (rst)
    desc_req_o && desc_vld_i |=> !desc_req_o);

  // R14
  desc_capture_chk: assert property (@(posedge clk) disable iff (rst)
    desc_req_o && desc_vld_i |=> desc_cur_o == $past(desc_word_i));

  // R4
  rbu_on_host_chk: assert property (@(posedge clk) disable iff (rst)
    desc_req_o && desc_vld_i && !desc_word_i[OWN_BIT] |=> rbu_o);

  // R6
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    drop_req_o && !drop_ack_i |=> drop_req_o);

  // R6
  miss_step_chk: assert property (@(posedge clk) disable iff (rst)
    drop_req_o && drop_ack_i && !miss_rd_i && miss_cnt_o != CNT_MAX
    |=> miss_cnt_o == $past(miss_cnt_o) + CNT_W'(1));

  // R9
  miss_sat_chk: assert property (@(posedge clk) disable iff (rst)
    miss_cnt_o == CNT_MAX && !miss_rd_i |=> miss_cnt_o == CNT_MAX);

  // R10
  miss_clear_chk: assert property (@(posedge clk) disable iff (rst)
    miss_rd_i && !(drop_req_o && drop_ack_i) |=> miss_cnt_o == '0);

  // R11
  stop_run_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == 2'd2 && !rx_busy_o && stop_i |=> state_o == 2'd0);

  // R13
  stopped_idle_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == 2'd0 && !start_i |=> state_o == 2'd0);

  // R13
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({desc_req_o, rx_busy_o, drop_req_o}));

endmodule

bind rxdma_susp_ctrl rxs_chk #(.CNT_W(CNT_W), .DESC_W(DESC_W), .OWN_BIT(OWN_BIT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .drop_ack_i  (drop_ack_i),
  .desc_vld_i  (desc_vld_i),
  .desc_word_i (desc_word_i),
  .miss_rd_i   (miss_rd_i),
  .desc_req_o  (desc_req_o),
  .rx_busy_o   (rx_busy_o),
  .drop_req_o  (drop_req_o),
  .rbu_o       (rbu_o),
  .miss_cnt_o  (miss_cnt_o),
  .desc_cur_o  (desc_cur_o),
  .state_o     (state_o)
);

// File: tb/sim_rxdma_susp_ctrl.sv
module sim_rxdma_susp_ctrl;

  localparam int CW   = 4;
  localparam int MAXC = 15;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, start = 1'b0, stop = 1'b0, poll = 1'b0, fdis = 1'b0;
  logic arrive = 1'b0, avail = 1'b0, done = 1'b0, ack = 1'b0, vld = 1'b0;
  logic [31:0] word = '0;
  logic rd = 1'b0, clr = 1'b0;
  logic desc_req_o, rx_busy_o, drop_req_o, rbu_o;
  logic [CW-1:0] miss_cnt_o;
  logic [31:0] desc_cur_o;
  logic [1:0] state_o;

  rxdma_susp_ctrl #(.CNT_W(CW), .DESC_W(32), .OWN_BIT(31)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .stop_i(stop), .poll_i(poll),
    .flush_dis_i(fdis), .frm_arrive_i(arrive), .frm_avail_i(avail),
    .frm_done_i(done), .drop_ack_i(ack), .desc_vld_i(vld), .desc_word_i(word),
    .miss_rd_i(rd), .rbu_clr_i(clr), .desc_req_o(desc_req_o),
    .rx_busy_o(rx_busy_o), .drop_req_o(drop_req_o), .rbu_o(rbu_o),
    .miss_cnt_o(miss_cnt_o), .desc_cur_o(desc_cur_o), .state_o(state_o)
  );

  int n_cmp = 0, n_bad = 0;
  int nfr = 0, nfetch = 0;
  bit cmp_on = 0, fast = 1, own_nx = 1'b1, rd_on_ack = 0;
  bit q_start, q_stop, q_poll, q_arrive, q_rd, q_clr;

  // reference model: 0 stop,1 fetch,2 run,3 xfer,4 susp,5 drop,6 recheck
  int m_st = 0, m_miss = 0;
  bit m_why = 0, m_rbu = 0;
  logic [31:0] m_desc = '0;

  always @(posedge clk) begin
    bit rset, inc;
    rset = 0; inc = 0;
    if (rst) begin
      m_st = 0; m_why = 0; m_rbu = 0; m_miss = 0; m_desc = '0;
    end else begin
      case (m_st)
        0: if (start) begin m_st = 1; m_why = 0; end
        1: if (vld) begin
             m_desc = word;
             if (word[31]) m_st = 2;
             else begin rset = 1; m_st = (m_why && !fdis) ? 5 : 4; end
           end
        2: if (stop) m_st = 0; else if (avail) m_st = 3;
        3: if (done) begin m_st = 1; m_why = 0; end
        4: if (stop) m_st = 0;
           else if (arrive) begin m_st = 1; m_why = 1; end
           else if (poll) begin m_st = 1; m_why = 0; end
        5: if (ack) begin inc = 1; m_st = 6; end
        default: if (avail) begin m_st = 1; m_why = 1; end else m_st = 4;
      endcase
      if (rset) m_rbu = 1; else if (clr) m_rbu = 0;
      if (rd) m_miss = inc ? 1 : 0;
      else if (inc && m_miss < MAXC) m_miss = m_miss + 1;
    end
  end

  function automatic int code_of(int s);
    if (s == 0) return 0;
    if (s == 1) return 1;
    if (s == 2 || s == 3) return 2;
    return 3;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R13 state_o", state_o, code_of(m_st));
    chk("R2 desc_req_o", desc_req_o, m_st == 1);
    chk("R3 rx_busy_o", rx_busy_o, m_st == 3);
    chk("R6 drop_req_o", drop_req_o, m_st == 5);
    chk("R12 rbu_o", rbu_o, m_rbu);
    chk("R9 miss_cnt_o", miss_cnt_o, m_miss);
    chk("R14 desc_cur_o", desc_cur_o, m_desc);
  endtask

  task automatic step();
    @(negedge clk);
    if (cmp_on) compare();
    if (ack) nfr--;
    if (done) nfr--;
    if (nfr < 0) nfr = 0;
    arrive = q_arrive;
    if (q_arrive) nfr++;
    start = q_start; stop = q_stop; poll = q_poll; clr = q_clr;
    vld  = desc_req_o && (fast || $urandom_range(0, 2) == 0);
    word = {own_nx, 31'($urandom)};
    if (vld) nfetch++;
    ack  = drop_req_o && (fast || $urandom_range(0, 1) == 0);
    rd   = q_rd | (rd_on_ack & ack);
    done = rx_busy_o && $urandom_range(0, 2) == 0;
    avail = (nfr > 0);
    q_start = 0; q_stop = 0; q_poll = 0; q_arrive = 0; q_rd = 0; q_clr = 0;
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_code(int c);
    for (int i = 0; i < 200 && state_o != 2'(c); i++) step();
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n0;
    {q_start, q_stop, q_poll, q_arrive, q_rd, q_clr} = '0;
    run_n(2);
    cmp_on = 1;
    step();
    // R1 reset values
    chk("R1 state", state_o, 0);
    chk("R1 requests", {desc_req_o, rx_busy_o, drop_req_o}, 0);
    chk("R1 rbu", rbu_o, 0);
    chk("R1 miss", miss_cnt_o, 0);
    chk("R1 desc", desc_cur_o, 0);
    rst = 1'b0;

    // R3: start, owned descriptor, one frame transferred
    own_nx = 1; q_start = 1; step();
    wait_code(2);
    chk("R3 in run", state_o, 2);
    own_nx = 0; q_arrive = 1; step();
    wait_code(3);
    run_n(3);
    // R4: host-owned after transfer goes to suspend without drop
    chk("R4 suspended", state_o, 3);
    chk("R4 rbu set", rbu_o, 1);
    chk("R4 no miss", miss_cnt_o, 0);

    // R12 clear
    q_clr = 1; run_n(3);
    chk("R12 cleared", rbu_o, 0);

    // R6 single drop
    fdis = 0; q_arrive = 1; step(); run_n(12);
    chk("R6 one miss", miss_cnt_o, 1);
    chk("R6 fifo emptied", nfr, 0);

    // R7 two queued frames both dropped
    q_arrive = 1; step(); q_arrive = 1; step(); run_n(20);
    chk("R7 repeated drops", miss_cnt_o, 3);
    chk("R7 fifo emptied", nfr, 0);

    // R8 flush disabled keeps frame
    fdis = 1; q_arrive = 1; step(); run_n(10);
    chk("R8 miss unchanged", miss_cnt_o, 3);
    chk("R8 frame kept", nfr, 1);
    chk("R8 suspended", state_o, 3);

    // R5 arrival and poll together -> one refetch; poll alone -> one
    n0 = nfetch; q_arrive = 1; q_poll = 1; step(); run_n(10);
    chk("R5 single refetch", nfetch - n0, 1);
    n0 = nfetch; q_poll = 1; step(); run_n(10);
    chk("R5 poll refetch", nfetch - n0, 1);
    n0 = nfetch; run_n(10);
    chk("R5 idle no refetch", nfetch - n0, 0);

    // R10 read clear, then reads coinciding with acks
    q_rd = 1; run_n(2);
    chk("R10 read clears", miss_cnt_o, 0);
    fdis = 0; rd_on_ack = 1; q_arrive = 1; step(); run_n(25);
    rd_on_ack = 0;
    chk("R10 read with drop", miss_cnt_o, 1);
    chk("R10 fifo emptied", nfr, 0);

    // R9 saturation
    for (int k = 0; k < 20; k++) begin
      q_arrive = 1; step(); run_n(8);
    end
    chk("R9 saturated", miss_cnt_o, MAXC);

    // R11 stop from suspend and from run
    q_stop = 1; run_n(2);
    chk("R11 stop in suspend", state_o, 0);
    own_nx = 1; q_start = 1; step(); wait_code(2);
    if (rx_busy_o) begin own_nx = 1; wait_code(2); end
    nfr = 0; avail = 0;
    q_stop = 1; run_n(2);
    chk("R11 stop in run", state_o, 0);

    // random phase
    fast = 0;
    for (int k = 0; k < 4000; k++) begin
      q_start  = ($urandom_range(0, 19) == 0);
      q_stop   = ($urandom_range(0, 59) == 0);
      q_poll   = ($urandom_range(0, 14) == 0);
      q_arrive = ($urandom_range(0, 5) == 0);
      q_rd     = ($urandom_range(0, 24) == 0);
      q_clr    = ($urandom_range(0, 9) == 0);
      own_nx   = ($urandom_range(0, 1) == 0);
      if ($urandom_range(0, 39) == 0) fdis = ~fdis;
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule